// File: doc/BRIEF.md
# Bit-per-clock parity receiver with byte queue

This block takes a serial stream that carries one bit per clock cycle and turns each framed transfer into a byte. An upstream circuit marks the frame with a one-cycle start strobe. The block then captures eight data bits, least significant first, and one parity bit on the clock edges that follow. It takes no oversampling, start-bit search or stop-bit handling.

The parity bit is checked against the data under even or odd parity, selected by a static input. A byte with good parity goes into an eight-entry queue whose head word is always visible on the read port. A byte with bad parity is discarded, and a one-cycle error pulse is raised. A good byte that finds the queue full is lost and sets a sticky overflow flag. A consumer drains the queue with a read enable and uses the empty and full flags.

Top module: `par_serial_rx`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `parity_err` and `overflow` are 0.
- R2: The `ser_in` level in the strobe cycle is not used. Counting the strobe edge as edge 0, edges 1 to 8 capture data bits 0 to 7 (LSB first).
- R3: With `odd_par` = 0 a frame is good when the eight data bits and the parity bit taken at edge 9 hold an even number of ones.
- R4: With `odd_par` = 1 a frame is good when those nine bits hold an odd number of ones.
- R5: A good byte is written on edge 10. `empty` stays 1 through the cycle after edge 9 and falls after edge 10, with the byte on `rd_data`.
- R6: A bad-parity byte is never written. `parity_err` is 1 for exactly the one cycle after edge 9.
- R7: A start strobe that comes while a frame is being captured (edges 1 to 9) is ignored.
- R8: The queue is first-in first-out, and `rd_data` shows the oldest byte while `empty` is 0. With `rd_en` high, an edge removes that byte. A read while empty has no effect.
- R9: `full` rises after eight bytes are held. A good byte that arrives while full is dropped and sets `overflow`, which stays 1 until reset.
- R10: A strobe on edge 10, the edge right after the parity edge, starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data line |
| start | input | 1 | One-cycle frame start strobe |
| odd_par | input | 1 | Static parity select: 0 even, 1 odd |
| rd_en | input | 1 | Pop the head byte of the queue |
| rd_data | output | 8 | Head byte of the queue (first-word fall-through) |
| empty | output | 1 | Queue holds no byte |
| full | output | 1 | Queue holds eight bytes |
| parity_err | output | 1 | One-cycle pulse on a parity failure |
| overflow | output | 1 | Sticky: a good byte was dropped on a full queue |

## Verification
Some properties are checked on every cycle. The error pulse lasts one cycle and never coincides with a queue write. A frame in progress advances its bit count whatever `start` does. `full` and `empty` are never both set. `overflow` never falls, and a read of an empty queue leaves it empty. The bench scenarios are needed for the rest: LSB-first bit order, the parity verdict under both polarities, the exact edge on which a byte appears, the FIFO order across a full queue, and back-to-back frames. Each of these needs expected byte values that only the stimulus knows.

// File: rtl/par_rx_pkg.sv
package par_rx_pkg;
  // Parity verdict for a captured word plus its parity bit.
  function automatic logic parity_good(input logic [7:0] data, input logic pbit,
                                       input logic odd_sel);
    return ((^data) ^ pbit) == odd_sel;
  endfunction
endpackage

// File: rtl/rx_frame.sv
module rx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              start,
  input  logic              odd_par,
  output logic [DATA_W-1:0] word_o,
  output logic              wr_o,
  output logic              perr_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              wr_q, wr_d;
  logic              perr_q, perr_d;
  logic              verdict_ok;

  assign verdict_ok = ((^shift_q) ^ ser_in) == odd_par;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    wr_d    = 1'b0;
    perr_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (cnt_q != LAST) begin
      shift_d[cnt_q[IDX_W-1:0]] = ser_in;
      cnt_d = cnt_q + 1'b1;
    end else begin
      busy_d = 1'b0;
      if (verdict_ok) wr_d = 1'b1;
      else            perr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      wr_q    <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (busy_q) shift_q <= shift_d;
      wr_q   <= wr_d;
      perr_q <= perr_d;
    end
  end

  assign word_o = shift_q;
  assign wr_o   = wr_q;
  assign perr_o = perr_q;

  // R6
  perr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |=> !perr_q);
  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(perr_q && wr_q));
  // R7
  frame_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R5
  verdict_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> (!busy_q && (wr_q || perr_q)));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             wr_go, rd_go;

  assign full  = (cnt_q == CNT_FULL);
  assign empty = (cnt_q == '0);
  assign wr_go = wr_i && !full;
  assign rd_go = rd_en && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q | (wr_i && full);
    if (wr_go) wp_d = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
    if (rd_go) rp_d = (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
    case ({wr_go, rd_go})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) mem_q[wp_q] <= wr_data;
  end

  assign rd_data  = mem_q[rp_q];
  assign overflow = ovf_q;

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R9
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full && !rd_en) |=> (full && overflow));
  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_i) |=> empty);
endmodule

// File: rtl/par_serial_rx.sv
module par_serial_rx #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              start,
  input  logic              odd_par,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              parity_err,
  output logic              overflow
);
  logic [DATA_W-1:0] word;
  logic              word_wr;

  rx_frame #(.DATA_W(DATA_W)) frame_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_in (ser_in),
    .start  (start),
    .odd_par(odd_par),
    .word_o (word),
    .wr_o   (word_wr),
    .perr_o (parity_err)
  );

  rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (word_wr),
    .wr_data (word),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (empty),
    .full    (full),
    .overflow(overflow)
  );
endmodule

// File: tb/par_serial_rx_tb_top.sv
module par_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, ser_in, start, odd_par, rd_en;
  logic [7:0] rd_data;
  logic       empty, full, parity_err, overflow;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  par_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .start(start), .odd_par(odd_par),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(full),
    .parity_err(parity_err), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic good_pbit(input logic [7:0] d);
    return odd_par ? ~(^d) : (^d);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // Returns 1 ns after edge 9 (the parity edge).
  task automatic send_frame(input logic [7:0] d, input logic pbit, input bit mid_strobe);
    @(negedge clk);
    start  = 1'b1;
    ser_in = ~d[0];
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      start  = mid_strobe && (i == 3);
      ser_in = d[i];
    end
    @(negedge clk);
    start  = 1'b0;
    ser_in = pbit;
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string req);
    chk(!empty, req, "empty before pop", int'(empty), 0);
    chk(rd_data == exp, req, "rd_data", int'(rd_data), int'(exp));
    @(negedge clk); rd_en = 1'b1;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(empty == 1'b1, "R1", "empty", int'(empty), 1);
    chk(full == 1'b0, "R1", "full", int'(full), 0);
    chk(parity_err == 1'b0, "R1", "parity_err", int'(parity_err), 0);
    chk(overflow == 1'b0, "R1", "overflow", int'(overflow), 0);
  endtask

  task automatic t_even_good();
    logic [7:0] pats [4] = '{8'h01, 8'hA5, 8'h80, 8'h3C};
    odd_par = 1'b0;
    foreach (pats[k]) begin
      send_frame(pats[k], good_pbit(pats[k]), 1'b0);
      chk(parity_err == 1'b0, "R3", "parity_err on good", int'(parity_err), 0);
      chk(empty == 1'b1, "R5", "empty after edge 9", int'(empty), 1);
      settle();
      chk(empty == 1'b0, "R5", "empty after edge 10", int'(empty), 0);
      pop_expect(pats[k], "R2");
      chk(empty == 1'b1, "R8", "empty after pop", int'(empty), 1);
    end
  endtask

  task automatic t_bad(input logic oddsel, input string req);
    odd_par = oddsel;
    send_frame(8'h5B, ~good_pbit(8'h5B), 1'b0);
    chk(parity_err == 1'b1, "R6", "parity_err pulse", int'(parity_err), 1);
    settle();
    chk(parity_err == 1'b0, "R6", "parity_err one cycle", int'(parity_err), 0);
    chk(empty == 1'b1, req, "bad byte not stored", int'(empty), 1);
    repeat (3) settle();
    chk(empty == 1'b1, "R6", "still empty", int'(empty), 1);
  endtask

  task automatic t_odd_good();
    odd_par = 1'b1;
    send_frame(8'hC3, good_pbit(8'hC3), 1'b0);
    chk(parity_err == 1'b0, "R4", "parity_err odd good", int'(parity_err), 0);
    settle();
    pop_expect(8'hC3, "R4");
    odd_par = 1'b0;
  endtask

  task automatic t_mid_strobe();
    send_frame(8'h96, good_pbit(8'h96), 1'b1);
    chk(parity_err == 1'b0, "R7", "no error with mid strobe", int'(parity_err), 0);
    settle();
    pop_expect(8'h96, "R7");
    repeat (12) settle();
    chk(empty == 1'b1, "R7", "no extra frame", int'(empty), 1);
    chk(parity_err == 1'b0, "R7", "no late error", int'(parity_err), 0);
  endtask

  task automatic t_back2back();
    send_frame(8'h12, good_pbit(8'h12), 1'b0);
    send_frame(8'hEF, good_pbit(8'hEF), 1'b0);
    chk(parity_err == 1'b0, "R10", "second frame parity", int'(parity_err), 0);
    settle();
    pop_expect(8'h12, "R10");
    pop_expect(8'hEF, "R10");
    chk(empty == 1'b1, "R10", "empty after two pops", int'(empty), 1);
  endtask

  task automatic t_empty_read();
    @(negedge clk); rd_en = 1'b1;
    repeat (2) settle();
    rd_en = 1'b0;
    chk(empty == 1'b1, "R8", "empty read ignored", int'(empty), 1);
    send_frame(8'h44, good_pbit(8'h44), 1'b0);
    settle();
    pop_expect(8'h44, "R8");
  endtask

  task automatic t_fill_overflow();
    do_reset();
    for (int k = 0; k < 8; k++) begin
      send_frame(8'(8'h20 + k * 7), good_pbit(8'(8'h20 + k * 7)), 1'b0);
      settle();
    end
    chk(full == 1'b1, "R9", "full after eight", int'(full), 1);
    chk(overflow == 1'b0, "R9", "no overflow yet", int'(overflow), 0);
    send_frame(8'hFF, good_pbit(8'hFF), 1'b0);
    settle();
    chk(overflow == 1'b1, "R9", "overflow set", int'(overflow), 1);
    for (int k = 0; k < 8; k++) pop_expect(8'(8'h20 + k * 7), "R8");
    chk(empty == 1'b1, "R9", "ninth byte dropped", int'(empty), 1);
    chk(overflow == 1'b1, "R9", "overflow sticky", int'(overflow), 1);
    do_reset();
    chk(overflow == 1'b0, "R1", "overflow cleared by reset", int'(overflow), 0);
  endtask

  initial begin
    rst_n = 1'b0; ser_in = 1'b0; start = 1'b0; odd_par = 1'b0; rd_en = 1'b0;
    t_reset();
    t_even_good();
    t_bad(1'b0, "R3");
    t_bad(1'b1, "R4");
    t_odd_good();
    t_mid_strobe();
    t_back2back();
    t_empty_read();
    t_fill_overflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule